// File: doc/BRIEF.md
# Fetch Stash Buffer

This block sits between an instruction cache and a decode stage. The cache has a fixed one-cycle read latency and has no stall input. Every cycle the block receives the cache's result bundle: a valid bit, a 32-bit instruction word, the 64-bit fetch address of that word, and a one-bit stop mark used for debug stepping. It drives a registered copy of that bundle to decode.

Decode may stall at any time. By the time a stall is visible upstream, the address stage has already moved on, and one more cache result is on its way. The block therefore keeps a single-entry stash. A valid result that arrives while decode is stalled goes into the stash. When the stall drops, the stashed entry goes to decode before any live cache output. The upstream stages must present nothing while stalled after that one in-flight result, and they must present nothing in the cycle the stall is released. The block carries no other flow control.

A flush discards both the stash and the output register. The valid bit toward decode is forced low for the whole flush cycle.

Top module: `fetch_stash`

## Requirements
- R1: A synchronous active-high reset clears the output register and the stash. `out_valid` reads 0 after reset. An entry captured before the reset is never delivered.
- R2: With no stall, no flush and an empty stash, a valid input bundle appears on the outputs one clock later, with all fields unchanged: address, instruction and stop mark.
- R3: While `stall` is high and `flush` is low, the output register keeps its valid bit, address, instruction and stop mark unchanged across the clock edge.
- R4: While `stall` is high, a valid input is captured into the empty stash, with all fields. A valid input while the stash is already full is a protocol violation. The upstream stages never cause one.
- R5: In the first cycle with `stall` low, a full stash is loaded into the output register and the stash becomes empty. After that, live inputs pass straight through again.
- R6: While `flush` is high, `out_valid` is 0. At the clock edge, the stash and the output register are both emptied and the input of that cycle is dropped.
- R7: Under any pattern of stall and flush, every input accepted outside a flush is delivered to decode exactly once and in order, unless a later flush discards it. A delivery is a cycle with `out_valid` high and `stall` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard the held and stashed results |
| stall | input | 1 | Decode stall; output register must hold |
| in_valid | input | 1 | Cache result valid |
| in_insn | input | 32 | Cache instruction word |
| in_addr | input | 64 | Fetch address of the instruction |
| in_stop | input | 1 | Stop mark of the instruction |
| out_valid | output | 1 | Bundle to decode is valid (low during flush) |
| out_insn | output | 32 | Instruction to decode |
| out_addr | output | 64 | Fetch address to decode |
| out_stop | output | 1 | Stop mark to decode |

## Verification
The bench targets the one-cycle stall, where the in-flight result lands in the stash. A design that failed to capture it would drop an address. A design that forwarded the live input on release would show the stashed word late or twice. Flushes are placed in stall cycles and in release cycles. A stash that survived a flush would deliver a stale instruction after the flush. An output that was not gated would show a valid bit during the flush cycle. A reset with a full stash checks that no entry leaks out afterwards. Long random stall and flush patterns are then compared against an in-order reference queue, which catches drops, duplicates and reordering.

// File: rtl/fstash_pkg.sv
package fstash_pkg;

  // Source of the next value for the output register
  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_LIVE  = 2'd1,
    SEL_STASH = 2'd2,
    SEL_CLEAR = 2'd3
  } out_sel_e;

  // Width of the packed bundle payload: {stop, insn, addr}
  function automatic int payload_width(input int insn_w, input int addr_w);
    return insn_w + addr_w + 1;
  endfunction

endpackage

// File: rtl/fstash_slot.sv
// One bundle register: valid bit with reset and clear, data without reset.
module fstash_slot #(
  parameter int W = 97
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic         d_valid,
  input  logic [W-1:0] d_data,
  output logic         q_valid,
  output logic [W-1:0] q_data
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q_valid <= 1'b0;
    end else if (load) begin
      q_valid <= d_valid;
    end
  end

  // Payload is only written alongside a valid bit, no reset needed
  always_ff @(posedge clk) begin
    if (load && d_valid) begin
      q_data <= d_data;
    end
  end

endmodule

// File: rtl/fstash_ctrl.sv
// Decides, per cycle, what the output register and the stash do.
module fstash_ctrl
  import fstash_pkg::*;
(
  input  logic     flush,
  input  logic     stall,
  input  logic     in_valid,
  input  logic     stash_valid,
  output out_sel_e sel,
  output logic     stash_load,
  output logic     stash_clr
);

  always_comb begin
    sel        = SEL_LIVE;
    stash_load = 1'b0;
    stash_clr  = 1'b0;
    if (flush) begin
      sel       = SEL_CLEAR;
      stash_clr = 1'b1;
    end else if (stall) begin
      sel        = SEL_HOLD;
      stash_load = in_valid && !stash_valid;
    end else if (stash_valid) begin
      sel       = SEL_STASH;
      stash_clr = 1'b1;
    end
  end

endmodule

// File: rtl/fetch_stash.sv
module fetch_stash
  import fstash_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              stall,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_stop,
  output logic              out_valid,
  output logic [INSN_W-1:0] out_insn,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_stop
);

  localparam int PW       = payload_width(INSN_W, ADDR_W);
  localparam int INSN_LSB = ADDR_W;
  localparam int STOP_BIT = ADDR_W + INSN_W;

  logic [PW-1:0] in_payload;
  logic [PW-1:0] stash_data_q;
  logic [PW-1:0] hold_data_q;
  logic [PW-1:0] hold_nxt_data;
  logic          stash_valid_q;
  logic          hold_valid_q;
  logic          hold_nxt_valid;
  logic          hold_load;
  logic          hold_clr;
  logic          stash_load;
  logic          stash_clr;
  out_sel_e      sel;

  assign in_payload = {in_stop, in_insn, in_addr};

  fstash_ctrl u_ctrl (
    .flush       (flush),
    .stall       (stall),
    .in_valid    (in_valid),
    .stash_valid (stash_valid_q),
    .sel         (sel),
    .stash_load  (stash_load),
    .stash_clr   (stash_clr)
  );

  // Output register source select
  always_comb begin
    hold_nxt_valid = 1'b0;
    hold_nxt_data  = in_payload;
    unique case (sel)
      SEL_LIVE: begin
        hold_nxt_valid = in_valid;
        hold_nxt_data  = in_payload;
      end
      SEL_STASH: begin
        hold_nxt_valid = stash_valid_q;
        hold_nxt_data  = stash_data_q;
      end
      default: begin
        hold_nxt_valid = 1'b0;
        hold_nxt_data  = in_payload;
      end
    endcase
  end

  assign hold_load = (sel == SEL_LIVE) || (sel == SEL_STASH);
  assign hold_clr  = (sel == SEL_CLEAR);

  fstash_slot #(.W(PW)) u_stash (
    .clk     (clk),
    .rst     (rst),
    .clr     (stash_clr),
    .load    (stash_load),
    .d_valid (in_valid),
    .d_data  (in_payload),
    .q_valid (stash_valid_q),
    .q_data  (stash_data_q)
  );

  fstash_slot #(.W(PW)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .clr     (hold_clr),
    .load    (hold_load),
    .d_valid (hold_nxt_valid),
    .d_data  (hold_nxt_data),
    .q_valid (hold_valid_q),
    .q_data  (hold_data_q)
  );

  assign out_valid = hold_valid_q && !flush;
  assign out_addr  = hold_data_q[ADDR_W-1:0];
  assign out_insn  = hold_data_q[INSN_LSB +: INSN_W];
  assign out_stop  = hold_data_q[STOP_BIT];

endmodule

// File: rtl/fstash_checker.sv
module fstash_checker #(
  parameter int INSN_W = 32,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              stall,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [INSN_W-1:0] out_insn,
  input logic              out_stop,
  input logic              stash_valid_q,
  input logic [ADDR_W-1:0] stash_addr,
  input logic              hold_valid_q
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> !hold_valid_q && !stash_valid_q);

  p_pass_through_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !stall && !flush && !stash_valid_q)
      |=> hold_valid_q && out_addr == $past(in_addr));

  p_hold_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush)
      |=> $stable(hold_valid_q) && $stable(out_addr) && $stable(out_insn) && $stable(out_stop));

  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush && in_valid && !stash_valid_q)
      |=> stash_valid_q && stash_addr == $past(in_addr));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    stash_valid_q |-> !in_valid || flush);

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (!stall && !flush && stash_valid_q)
      |=> hold_valid_q && !stash_valid_q && out_addr == $past(stash_addr));

  p_flush_gate_r6: assert property (@(posedge clk) disable iff (rst)
    flush |-> !out_valid);

  p_flush_empty_r6: assert property (@(posedge clk) disable iff (rst)
    flush |=> !hold_valid_q && !stash_valid_q);

endmodule

bind fetch_stash fstash_checker #(.INSN_W(INSN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .flush         (flush),
  .stall         (stall),
  .in_valid      (in_valid),
  .in_addr       (in_addr),
  .out_valid     (out_valid),
  .out_addr      (out_addr),
  .out_insn      (out_insn),
  .out_stop      (out_stop),
  .stash_valid_q (stash_valid_q),
  .stash_addr    (stash_data_q[ADDR_W-1:0]),
  .hold_valid_q  (hold_valid_q)
);

// File: tb/fetch_stash_test.sv
`timescale 1ns/1ps
module fetch_stash_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        stall = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic [63:0] in_addr = '0;
  logic        in_stop = 1'b0;
  logic        out_valid;
  logic [31:0] out_insn;
  logic [63:0] out_addr;
  logic        out_stop;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit stall_prev = 1'b0;
  logic [63:0] next_addr = 64'h100;
  logic [63:0] ref_q[$];

  always #2 clk = ~clk;

  fetch_stash uut (
    .clk (clk), .rst (rst), .flush (flush), .stall (stall),
    .in_valid (in_valid), .in_insn (in_insn), .in_addr (in_addr), .in_stop (in_stop),
    .out_valid (out_valid), .out_insn (out_insn), .out_addr (out_addr), .out_stop (out_stop)
  );

  function automatic logic [31:0] insn_of(input logic [63:0] a);
    return a[31:0] ^ 32'h5A3C_0F96;
  endfunction

  function automatic logic stop_of(input logic [63:0] a);
    return ^a[6:2];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Check the full bundle currently shown to decode
  task automatic chk_out(input string req, input logic [63:0] a);
    chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
    chk({req, " addr"}, out_addr, a);
    chk({req, " insn"}, {32'd0, out_insn}, {32'd0, insn_of(a)});
    chk({req, " stop"}, {63'd0, out_stop}, {63'd0, stop_of(a)});
  endtask

  // One cycle: the source stops one cycle after it sees a stall
  task automatic step(input bit s, input bit f, input bit w);
    logic [63:0] e;
    stall    = s;
    flush    = f;
    in_valid = w && !stall_prev;
    in_addr  = next_addr;
    in_insn  = insn_of(next_addr);
    in_stop  = stop_of(next_addr);
    #1;
    if (f) chk("R6 out_valid in flush cycle", {63'd0, out_valid}, 64'd0);
    if (out_valid && !s) begin
      if (ref_q.size() == 0) begin
        chk("R7 delivery with nothing pending", 64'd1, 64'd0);
      end else begin
        e = ref_q.pop_front();
        chk("R7 order addr", out_addr, e);
        chk("R7 insn", {32'd0, out_insn}, {32'd0, insn_of(e)});
        chk("R7 stop", {63'd0, out_stop}, {63'd0, stop_of(e)});
      end
    end
    if (f) ref_q.delete();
    if (in_valid && !f) ref_q.push_back(next_addr);
    if (f) next_addr = (next_addr & ~64'hFFF) + 64'h1000;
    else if (in_valid) next_addr = next_addr + 64'd4;
    stall_prev = s;
    @(posedge clk);
    #1;
    flush    = 1'b0;
    in_valid = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    #1;
    chk("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);

    step(0, 0, 1);
    chk_out("R2 pass-through first", 64'h100);
    step(0, 0, 1);
    chk_out("R2 pass-through second", 64'h104);

    // Stall rises; 0x108 is in flight and goes to the stash
    step(1, 0, 1);
    chk_out("R3 held on stall", 64'h104);
    step(1, 0, 1);
    chk_out("R3 held on long stall", 64'h104);
    // Release: stash is delivered first
    step(0, 0, 1);
    chk_out("R5 stash delivered on release", 64'h108);
    step(0, 0, 1);
    chk_out("R5 live after stash emptied", 64'h10C);

    // Stash 0x110, then flush during the stall
    step(1, 0, 1);
    chk_out("R4 held while capturing", 64'h10C);
    step(1, 1, 1);
    chk("R6 output empty after flush", {63'd0, out_valid}, 64'd0);
    step(0, 0, 1);
    chk("R6 stash discarded by flush", {63'd0, out_valid}, 64'd0);
    step(0, 0, 1);
    chk_out("R6 new stream after flush", 64'h1000);

    // Single-cycle stall: in-flight result lands in the stash
    step(1, 0, 1);
    step(0, 0, 1);
    chk_out("R4 captured entry delivered", 64'h1004);

    // Reset with a full stash: the entry must never appear
    step(1, 0, 1);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    ref_q.delete();
    stall_prev = 1'b1;
    next_addr = 64'h2000;
    #1;
    chk("R1 out_valid after mid-run reset", {63'd0, out_valid}, 64'd0);
    step(0, 0, 1);
    chk("R1 stash not delivered after reset", {63'd0, out_valid}, 64'd0);

    // Random stall and flush patterns against the reference queue
    for (int i = 0; i < 6000; i++) begin
      step($urandom_range(0, 99) < 35, $urandom_range(0, 99) < 3, $urandom_range(0, 99) < 80);
    end
    for (int i = 0; i < 6; i++) step(0, 0, 0);
    chk("R7 all accepted entries delivered", ref_q.size(), 64'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule